// File: doc/BRIEF.md
# Double-Buffered Reload PWM Timer

A down-counting timer that drives a pulse-width-modulated level from a single output flip-flop. Each output period is made of two phases: a low phase whose length comes from the primary reload value, and a high phase whose length comes from a buffered copy of the secondary reload value. Every time the counter passes zero in an enabled tick, the output flips, an interrupt pulse is raised for one cycle, and the counter is reloaded with the length of the phase that starts.

Software changes the waveform in two steps. It first writes the secondary (high-phase) value, which is only staged. It then writes the primary (low-phase) value, which commits the staged value together with it. The committed pair reaches the counter only at the period boundary, which is the end of the high phase. So a period always runs on one consistent pair and is never split between an old and a new setting. A write that lands in the boundary cycle itself misses that boundary and takes effect one period later.

Top module: `dbuf_pwm_timer`

## Requirements
- R1: While `rst` is high, `pwm_out`, `irq` and `rd_data` are 0 and the counter reads 0.
- R2: On the first clock edge where `run_en` is high after being low, the counter loads the committed primary value, `pwm_out` goes to 0 and the low phase begins. The secondary buffer also takes the committed secondary value at that edge.
- R3: On each edge with `run_en` high and `cnt_tick` high, a nonzero counter decreases by one. With `cnt_tick` low, the counter holds.
- R4: On an enabled tick with the counter at zero, `pwm_out` toggles and `irq` is 1 for exactly the following cycle. The counter then loads the buffered secondary value if the low phase ended, or the committed primary value if the high phase ended. A phase loaded with value V lasts V+1 ticks.
- R5: A write to address 1 stages a secondary value and has no effect on the waveform until a later write to address 0 commits it.
- R6: A write to address 0 updates the primary value and copies the staged secondary value into the committed slot in the same edge. Both take effect at the first period boundary after the write edge. A write on the boundary edge itself defers them by one full period.
- R7: The buffer that feeds the high-phase reload changes only at a period boundary (end of the high phase) or at start-up (R2), never at a register write.
- R8: While `run_en` is low, the counter and `pwm_out` hold their values and `irq` stays 0.
- R9: `rd_data` returns, one cycle after `rd_addr` is presented: the primary value for address 0, the staged secondary value (not the buffer) for address 1, the counter for address 2, and 0 for address 3.
- R10: Reload values of zero (one-tick phase) and all ones (2^W-tick phase) are accepted with no special treatment, giving near-0% and near-100% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 primary reload, 1 secondary reload |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address: 0 primary, 1 staged secondary, 2 counter |
| rd_data | output | CNT_W | Registered read data |
| run_en | input | 1 | Timer enable |
| cnt_tick | input | 1 | Count-clock enable, one tick per cycle when high |
| cnt_val | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM flip-flop output |
| irq | output | 1 | One-cycle pulse per underflow |

## Verification
Counter, output and interrupt changes are due on the same edge that samples the enabling tick, so they are visible one cycle after the inputs are applied. Read data follows its address by one edge. A committed pair first shows in the counter on the reload edge that ends the first high phase after the commit edge. The bench drives inputs on falling edges and runs a behavioural model on rising edges that reads only the bench's own stimulus. It compares all four outputs at every falling edge, so a result that appears one cycle early or late fails. Writes are swept across every offset from the boundary to cover the defer case.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PRIM = 2'd0;
  localparam logic [ADDR_W-1:0] A_SEC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
endpackage

// File: rtl/dbpwm_regs.sv
module dbpwm_regs #(
  parameter int W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [dbpwm_pkg::ADDR_W-1:0]  wr_addr,
  input  logic [W-1:0]                  wr_data,
  input  logic                          latch,
  output logic [W-1:0]                  prim_q,
  output logic [W-1:0]                  stage_q,
  output logic [W-1:0]                  buf_q
);
  import dbpwm_pkg::*;

  logic [W-1:0] commit_q;

  // staged and committed values; the commit copies the stage atomically
  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q   <= '0;
      stage_q  <= '0;
      commit_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PRIM) begin
        prim_q   <= wr_data;
        commit_q <= stage_q;
      end else if (wr_addr == A_SEC) begin
        stage_q  <= wr_data;
      end
    end
  end

  // buffer feeding the high-phase reload moves only at a boundary
  always_ff @(posedge clk) begin
    if (rst)        buf_q <= '0;
    else if (latch) buf_q <= commit_q;
  end
endmodule

// File: rtl/dbpwm_core.sv
module dbpwm_core #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic         cnt_tick,
  input  logic [W-1:0] prim,
  input  logic [W-1:0] buf_in,
  output logic [W-1:0] cnt_q,
  output logic         pwm_q,
  output logic         irq_q,
  output logic         run_q,
  output logic         latch
);
  import dbpwm_pkg::*;

  phase_e ph_q;
  logic   start;
  logic   step;
  logic   at_zero;

  assign start   = run_en && !run_q;
  assign step    = run_en && cnt_tick && !start;
  assign at_zero = (cnt_q == '0);
  assign latch   = start || (step && at_zero && ph_q == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
      irq_q <= 1'b0;
      run_q <= 1'b0;
      ph_q  <= PH_LOW;
    end else begin
      run_q <= run_en;
      irq_q <= 1'b0;
      if (start) begin
        cnt_q <= prim;
        pwm_q <= 1'b0;
        ph_q  <= PH_LOW;
      end else if (step) begin
        if (at_zero) begin
          irq_q <= 1'b1;
          pwm_q <= ~pwm_q;
          if (ph_q == PH_LOW) begin
            cnt_q <= buf_in;
            ph_q  <= PH_HIGH;
          end else begin
            cnt_q <= prim;
            ph_q  <= PH_LOW;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbpwm_rdmux.sv
module dbpwm_rdmux #(
  parameter int W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [dbpwm_pkg::ADDR_W-1:0]  rd_addr,
  input  logic [W-1:0]                  prim,
  input  logic [W-1:0]                  stage,
  input  logic [W-1:0]                  cnt,
  output logic [W-1:0]                  rd_q
);
  import dbpwm_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        A_PRIM:  rd_q <= prim;
        A_SEC:   rd_q <= stage;
        A_CNT:   rd_q <= cnt;
        default: rd_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_pwm_timer.sv
module dbuf_pwm_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             run_en,
  input  logic             cnt_tick,
  output logic [CNT_W-1:0] cnt_val,
  output logic             pwm_out,
  output logic             irq
);
  logic [CNT_W-1:0] prim_q;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] buf_q;
  logic             latch;
  logic             run_q;

  dbpwm_regs #(.W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch(latch),
    .prim_q(prim_q), .stage_q(stage_q), .buf_q(buf_q)
  );

  dbpwm_core #(.W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .run_en(run_en), .cnt_tick(cnt_tick),
    .prim(prim_q), .buf_in(buf_q),
    .cnt_q(cnt_val), .pwm_q(pwm_out), .irq_q(irq),
    .run_q(run_q), .latch(latch)
  );

  dbpwm_rdmux #(.W(CNT_W)) rdmux_i (
    .clk(clk), .rst(rst), .rd_addr(rd_addr),
    .prim(prim_q), .stage(stage_q), .cnt(cnt_val),
    .rd_q(rd_data)
  );
endmodule

// File: rtl/dbpwm_chk.sv
module dbpwm_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         run_en,
  input logic         run_q,
  input logic         cnt_tick,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] prim_q,
  input logic         pwm_out,
  input logic         irq
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(run_en && !run_q)) |-> (!pwm_out && cnt_val == $past(prim_q)));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(run_en && run_q && !cnt_tick)) |-> $stable(cnt_val));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && irq) |-> $past(run_en && run_q && cnt_tick && cnt_val == '0));

  // R4
  pwm_change_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && pwm_out != $past(pwm_out)) |-> (irq || !pwm_out));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(!run_en)) |-> ($stable(cnt_val) && $stable(pwm_out) && !irq));
endmodule

bind dbuf_pwm_timer dbpwm_chk #(.W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .run_en(run_en), .run_q(run_q),
  .cnt_tick(cnt_tick), .cnt_val(cnt_val), .prim_q(prim_q),
  .pwm_out(pwm_out), .irq(irq)
);

// File: tb/dbuf_pwm_timer_tb_top.sv
module dbuf_pwm_timer_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         run_en = 1'b0;
  logic         cnt_tick = 1'b0;
  logic [W-1:0] cnt_val;
  logic         pwm_out;
  logic         irq;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    tick_rand = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  string tag = "R1";

  always #10 clk = ~clk;

  dbuf_pwm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .run_en(run_en), .cnt_tick(cnt_tick),
    .cnt_val(cnt_val), .pwm_out(pwm_out), .irq(irq)
  );

  // behavioural reference
  logic [W-1:0] m_cnt, m_prim, m_stage, m_commit, m_buf, m_rd;
  logic         m_pwm, m_irq, m_runq, m_high;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_prim = '0; m_stage = '0; m_commit = '0; m_buf = '0; m_rd = '0;
      m_pwm = 0; m_irq = 0; m_runq = 0; m_high = 0;
    end else begin
      case (rd_addr)
        2'd0: m_rd = m_prim;
        2'd1: m_rd = m_stage;
        2'd2: m_rd = m_cnt;
        default: m_rd = '0;
      endcase
      m_irq = 0;
      if (run_en && !m_runq) begin
        m_cnt = m_prim; m_pwm = 0; m_high = 0; m_buf = m_commit;
      end else if (run_en && cnt_tick) begin
        if (m_cnt == 0) begin
          m_irq = 1; m_pwm = !m_pwm;
          if (!m_high) begin m_cnt = m_buf; m_high = 1; end
          else begin m_cnt = m_prim; m_high = 0; m_buf = m_commit; end
        end else m_cnt = m_cnt - 1;
      end
      if (wr_en && wr_addr == 2'd0) begin m_commit = m_stage; m_prim = wr_data; end
      else if (wr_en && wr_addr == 2'd1) m_stage = wr_data;
      m_runq = run_en;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({tag, " R3 counter"}, cnt_val, m_cnt);
      chk({tag, " R4 pwm_out"}, pwm_out, m_pwm);
      chk({tag, " R4 irq"}, irq, m_irq);
      chk({tag, " R9 rd_data"}, rd_data, m_rd);
    end
  end

  // tick and read-address stimulus
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cnt_tick <= tick_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    rd_addr <= rd_addr + 2'd1;
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 counter", cnt_val, 0);
    chk("R1 rd_data", rd_data, 0);
    rst = 1'b0;
    idle(2);

    tag = "R2";
    wr(2'd1, 10'd3);
    wr(2'd0, 10'd4);
    run_en = 1'b1;
    idle(30);

    tag = "R5";
    wr(2'd1, 10'd6);
    idle(40);

    tag = "R6/R7";
    for (int k = 0; k < 14; k++) begin
      idle(k);
      wr(2'd1, W'(1 + k % 4));
      idle(k % 3);
      wr(2'd0, W'(2 + k % 3));
    end
    idle(30);

    tag = "R3";
    tick_rand = 1'b1;
    idle(200);

    tag = "R8";
    run_en = 1'b0;
    idle(20);
    wr(2'd1, 10'd5);
    wr(2'd0, 10'd2);
    run_en = 1'b1;
    idle(17);
    run_en = 1'b0;
    idle(5);
    run_en = 1'b1;
    idle(40);

    tag = "R10";
    tick_rand = 1'b0;
    wr(2'd1, 10'd0);
    wr(2'd0, 10'h3ff);
    idle(2200);
    wr(2'd1, 10'h3ff);
    wr(2'd0, 10'd0);
    idle(2200);

    finish_run();
  end
endmodule